// File: doc/BRIEF.md
# Bus Clock Enable Divider with Fractional Mode

This block derives a bus clock enable from the CPU core clock, which is its root clock. Every root cycle it decides whether the bus domain advances, and it drives a one-cycle enable pulse when it does. A six-bit setting controls the rate. In integer mode the enable fires once every N root cycles. In fractional mode the enable fires on N of every 32 root cycles, and those pulses are spread as evenly as a five-bit accumulator allows.

Software writes a new setting through a single-cycle write strobe. The setting waits in a pending register, and busy stays high until the end of the current output period. At that point the pending setting becomes active and busy drops. Software polls busy until it reads 0. While busy is high, the old setting keeps running unchanged. A second write made while busy is high replaces the pending value.

Top module: `busclk_div_gen`

## Requirements
- R1: After reset the block is in integer mode with a divide value of 1, busy is 0, and the enable is high in every root cycle.
- R2: In integer mode (setting bit 5 = 0, divide value N = bits 4:0, from 1 to 31), count k from the first cycle in which the setting is active. The enable is high in cycle k exactly when (k+1) mod N = 0.
- R3: In fractional mode (setting bit 5 = 1), let j = k mod 32. The enable is high in cycle k exactly when floor((j+1)·N/32) > floor(j·N/32). This gives N pulses in every 32 cycles.
- R4: A divide value of 0 behaves as a value of 1 in both modes, so the output never stalls.
- R5: Busy reads 1 in the cycle after a write is captured. The new setting is active from the first cycle in which busy reads 0 again.
- R6: A pending setting is applied only at a period boundary, never at the edge where the write itself is captured. In integer mode a boundary is a cycle in which the enable fires. In fractional mode it is the last cycle (k mod 32 = 31) of a 32-cycle frame. If the write is captured in cycle w, busy stays high for b−w cycles, where b is the first boundary cycle after w.
- R7: A write made while busy is high replaces the pending setting, and the last value written is the one applied.
- R8: While busy is high, the enable keeps following the previously active setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root (CPU core) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the setting, one cycle per write |
| cfg_wdata | input | 6 | Bits 4:0 hold the divide value; bit 5 selects fractional mode |
| bus_tick | output | 1 | One-cycle bus clock enable |
| busy | output | 1 | High while a written setting has not yet taken effect |

## Verification
The enable is decoded straight from the active counter state, so the bench samples it in the same cycle. It compares each sample with the closed-form rule for the cycle index, counted from the cycle in which the setting became active. Busy rises one edge after the write and falls at the edge that closes the boundary cycle. The bench predicts that boundary from the old setting's phase and compares the number of busy cycles with b−w. It then restarts its cycle index at the first cycle in which busy reads 0, because the new pattern is due from that cycle.

// File: rtl/busdiv_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus clock enable divider.
// Assumes: the mode bit sits directly above the divide value in the setting word.
package busdiv_pkg;
    typedef enum logic {
        BD_INTEGER  = 1'b0,
        BD_FRACTION = 1'b1
    } bd_mode_e;
endpackage

// File: rtl/busdiv_setting.sv
`timescale 1ns/1ps
// Holds the pending and the active divider setting and reports busy.
// Assumes: boundary is high in the last cycle of the current output period.
// A zero divide value is stored as 1. A write is never applied at its own capture edge.
module busdiv_setting
    import busdiv_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_val,
    input  logic             wr_frac,
    input  logic             boundary,
    output logic [DIV_W-1:0] act_val,
    output bd_mode_e         act_mode,
    output logic             load,
    output logic             busy
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] pend_val;
    bd_mode_e         pend_mode;
    logic             pend_vld;

    assign load = boundary && pend_vld;
    assign busy = pend_vld;

    // Capture writes into the pending slot and move the pending setting to active at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_val  <= ONE;
            pend_mode <= BD_INTEGER;
            pend_vld  <= 1'b0;
            act_val   <= ONE;
            act_mode  <= BD_INTEGER;
        end else begin
            if (load) begin
                act_val  <= pend_val;
                act_mode <= pend_mode;
            end
            if (wr_en) begin
                pend_val  <= (wr_val == '0) ? ONE : wr_val;
                pend_mode <= wr_frac ? BD_FRACTION : BD_INTEGER;
                pend_vld  <= 1'b1;
            end else if (load) begin
                pend_vld  <= 1'b0;
            end
        end
    end

    p_write_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);
    p_busy_waits_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !boundary) |=> busy);
    p_active_held_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_val) && $stable(act_mode)));
endmodule

// File: rtl/busdiv_intcnt.sv
`timescale 1ns/1ps
// Integer-mode period counter. It fires once every div_val root cycles.
// Assumes: div_val is never zero and changes only together with load.
module busdiv_intcnt #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div_val - DIV_W'(1));

    // Count up to div_val-1 and wrap. Restart on reset or when a new setting loads.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    p_cnt_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div_val);
endmodule

// File: rtl/busdiv_fracacc.sv
`timescale 1ns/1ps
// Fractional-mode rate accumulator. It adds div_val every cycle and fires on each carry.
// A frame counter marks the end of every 2**DIV_W cycle window.
// Assumes: div_val changes only together with load.
module busdiv_fracacc #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic             frame_end
);
    logic [DIV_W-1:0] acc;
    logic [DIV_W-1:0] frame;
    logic [DIV_W:0]   sum;

    assign sum       = {1'b0, acc} + {1'b0, div_val};
    assign tick      = sum[DIV_W];
    assign frame_end = &frame;

    // Advance the accumulator and the frame position. Restart both when a new setting loads.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            acc   <= '0;
            frame <= '0;
        end else begin
            acc   <= sum[DIV_W-1:0];
            frame <= frame + DIV_W'(1);
        end
    end

    p_frame_closes_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (acc == '0));
endmodule

// File: rtl/busclk_div_gen.sv
`timescale 1ns/1ps
// Bus clock enable divider with integer and N/2**DIV_W fractional modes.
// Assumes: clk is the CPU core clock. The setting word is {mode, value}.
// The enable is combinational from registered state, so it has no input-to-output path.
module busclk_div_gen
    import busdiv_pkg::*;
#(
    parameter int DIV_W = 5,
    localparam int CFG_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             bus_tick,
    output logic             busy
);
    logic [DIV_W-1:0] act_val;
    bd_mode_e         act_mode;
    logic             load;
    logic             boundary;
    logic             int_tick;
    logic             frac_tick;
    logic             frac_end;

    busdiv_setting #(.DIV_W(DIV_W)) u_setting (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_val   (cfg_wdata[DIV_W-1:0]),
        .wr_frac  (cfg_wdata[DIV_W]),
        .boundary (boundary),
        .act_val  (act_val),
        .act_mode (act_mode),
        .load     (load),
        .busy     (busy)
    );

    busdiv_intcnt #(.DIV_W(DIV_W)) u_intcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .div_val (act_val),
        .tick    (int_tick)
    );

    busdiv_fracacc #(.DIV_W(DIV_W)) u_fracacc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .div_val   (act_val),
        .tick      (frac_tick),
        .frame_end (frac_end)
    );

    // Select the enable and the period boundary that belong to the active mode.
    always_comb begin
        if (act_mode == BD_FRACTION) begin
            bus_tick = frac_tick;
            boundary = frac_end;
        end else begin
            bus_tick = int_tick;
            boundary = int_tick;
        end
    end

    p_busy_falls_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(boundary));
    p_int_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == BD_INTEGER && bus_tick && !load && act_val > DIV_W'(1)) |=> !bus_tick);
endmodule

// File: tb/busclk_div_gen_bench.sv
`timescale 1ns/1ps
module busclk_div_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       bus_tick;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit cur_fr;
    int cur_n;
    int k;

    always #4 clk = ~clk;

    busclk_div_gen u_busclk_div_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .bus_tick  (bus_tick),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_tick(input bit fr, input int n, input int kk);
        int ne = (n == 0) ? 1 : n;
        int j  = kk % 32;
        if (!fr) return ((kk + 1) % ne) == 0;
        return (((j + 1) * ne) / 32) != ((j * ne) / 32);
    endfunction

    function automatic int boundary_after(input bit fr, input int n, input int w);
        int ne = (n == 0) ? 1 : n;
        int b  = w + 1;
        while (fr ? (((b + 1) % 32) != 0) : (((b + 1) % ne) != 0)) b++;
        return b;
    endfunction

    task automatic observe(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(bus_tick === exp_tick(cur_fr, cur_n, k), req, $sformatf("tick k=%0d n=%0d fr=%0d", k, cur_n, cur_fr),
                int'(bus_tick), int'(exp_tick(cur_fr, cur_n, k)));
            k++;
        end
    endtask

    // Write a new setting (optionally a second one right after) and check busy, the old pattern and the new pattern.
    task automatic reprogram(input bit fr, input int n, input int pre, input bit two, input bit fr2, input int n2);
        int w, b, bcnt;
        bit nfr;
        int nn;
        string req_new;
        observe(pre, cur_fr ? "R3" : "R2");
        if (two) begin
            while (boundary_after(cur_fr, cur_n, k) - k < 3) observe(1, "R8");
        end
        @(negedge clk);
        chk(bus_tick === exp_tick(cur_fr, cur_n, k), "R8", "tick at write", int'(bus_tick), int'(exp_tick(cur_fr, cur_n, k)));
        cfg_we    = 1'b1;
        cfg_wdata = {fr, 5'(n)};
        w = k;
        b = boundary_after(cur_fr, cur_n, w);
        k++;
        bcnt = 0;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            if (two && g == 0) begin
                cfg_wdata = {fr2, 5'(n2)};
            end else begin
                cfg_we = 1'b0;
            end
            if (busy !== 1'b1) break;
            bcnt++;
            chk(bus_tick === exp_tick(cur_fr, cur_n, k), "R8", "old tick while busy", int'(bus_tick), int'(exp_tick(cur_fr, cur_n, k)));
            k++;
        end
        cfg_we = 1'b0;
        chk(bcnt == b - w, "R6", "busy cycle count", bcnt, b - w);
        nfr = two ? fr2 : fr;
        nn  = two ? n2 : n;
        req_new = two ? "R7" : ((nn == 0) ? "R4" : (nfr ? "R3" : "R2"));
        cur_fr = nfr;
        cur_n  = nn;
        k = 0;
        chk(bus_tick === exp_tick(cur_fr, cur_n, 0), "R5", "first tick of new setting", int'(bus_tick), int'(exp_tick(cur_fr, cur_n, 0)));
        k = 1;
        observe(63, req_new);
    endtask

    initial begin
        #1200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: the reset state is visible in the cycle in which reset is released.
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(bus_tick === 1'b1, "R1", "tick after reset", int'(bus_tick), 1);
        cur_fr = 1'b0;
        cur_n  = 1;
        k = 1;
        observe(10, "R1");
        // R2 / R4: sweep every integer divide value, including 0.
        for (int n = 0; n < 32; n++) reprogram(1'b0, n, n % 5, 1'b0, 1'b0, 0);
        // R3 / R4: sweep every fractional value, including 0.
        for (int n = 0; n < 32; n++) reprogram(1'b1, n, (n * 3) % 7, 1'b0, 1'b0, 0);
        // Mixed transitions between modes.
        reprogram(1'b0, 31, 2, 1'b0, 1'b0, 0);
        // R7: two writes back to back while busy; the second one is applied.
        reprogram(1'b1, 5, 3, 1'b1, 1'b0, 7);
        reprogram(1'b1, 17, 0, 1'b1, 1'b1, 9);
        reprogram(1'b0, 3, 1, 1'b0, 1'b0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule